// File: doc/BRIEF.md
# Configuration Image Boot Loader

This block fills a volatile bank of configuration registers from a nonvolatile image. A load is started by the supply leaving undervoltage lockout, or by a software reboot request. The load waits a fixed settling delay. It then reads one image byte per tick of a slower time base and writes each byte to the register at the matching index. While the load runs, the block refuses every host request.

Once the bank is loaded, a host request takes one of two paths:
- A direct register write updates the volatile bank at once. It leaves the image alone and is lost when power is removed.
- An image write starts a timed programming cycle of one nonvolatile byte. The new value reaches the registers only at the next load.

Requests that arrive while the block is busy are refused rather than queued. The register bank and the memory cells sit outside the block.

Top module: `cfg_boot_loader`

## Requirements
- R1: A load starts when `uvlo_ok` is first seen high after reset or after being low. A load also starts on `reboot_req` when `uvlo_ok` is high and both `load_busy` and `prog_busy` are low. A reboot request at any other time is ignored.
- R2: The first image read (`nv_rd`) occurs in cycle DELAY_CYC+TICK_DIV of the load, counting the first cycle with `load_busy` high as cycle 1. Each following read comes exactly TICK_DIV cycles after the previous one.
- R3: While `load_busy` is high, every host request is answered with `host_nack`. Such a request is not queued: it never produces a later register write or image write.
- R4: `load_busy` stays high for exactly DELAY_CYC+NREG*TICK_DIV+1 cycles, and never for more than LOAD_LIMIT_CYC cycles.
- R5: Register index N receives the byte read from image address NV_BASE+N, for N from 0 to NREG-1, in ascending order. `nv_rdata` is sampled at the end of the cycle after `nv_rd`, and the matching `reg_we` pulse appears in the next cycle.
- R6: Register indices NREG to 2^AW-1 are reserved. Neither the load nor the host ever writes them, and a host request aimed at one is NACKed.
- R7: An accepted request with `host_nv`=1 produces a one-cycle `nv_wr` pulse in the next cycle. That pulse carries `nv_addr`=NV_BASE+index and `nv_wdata` equal to the request data. `prog_busy` is high for exactly PROG_CYC cycles starting in that same cycle. During this time there is no `nv_rd`, and every host request is NACKed.
- R8: An accepted request with `host_nv`=0 produces, in the next cycle, one `reg_we` pulse with the request index and data, and no `nv_wr`.
- R9: Each request sampled with `host_req` high is answered in the next cycle by exactly one of `host_ack` or `host_nack`.
- R10: An image write leaves the register at that index unchanged. The new byte appears in the register only after the next load.
- R11: While `uvlo_ok` is low, no load runs and a running load stops at once. In the same condition `prog_busy` is cleared and host requests are NACKed. When power returns, a full load rewrites every register, replacing values that were written directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uvlo_ok | input | 1 | Supply above lockout threshold |
| reboot_req | input | 1 | Software reboot request pulse |
| host_req | input | 1 | Host write request |
| host_nv | input | 1 | 1: program image byte, 0: write register directly |
| host_addr | input | AW | Register / image index |
| host_wdata | input | DW | Request data |
| host_ack | output | 1 | Request accepted (cycle after request) |
| host_nack | output | 1 | Request refused (cycle after request) |
| nv_addr | output | NV_AW | Nonvolatile memory address |
| nv_rd | output | 1 | Image read strobe |
| nv_rdata | input | DW | Image read data, valid the cycle after `nv_rd` |
| nv_wr | output | 1 | Start programming one image byte |
| nv_wdata | output | DW | Byte to program |
| reg_we | output | 1 | Register bank write strobe |
| reg_waddr | output | AW | Register bank write index |
| reg_wdata | output | DW | Register bank write data |
| load_busy | output | 1 | Load in progress; host access inhibited |
| prog_busy | output | 1 | Image byte programming in progress |

## Verification
The hardest situations to reach from the ports are collisions between a running operation and a new request. These include a reboot during programming, a reboot and a host write during a load, and a supply drop in the middle of a load. The bench reaches them by counting cycles from the start edge, so each request lands well inside the busy window. It then proves that nothing was queued by counting every register and image write until the next load finishes. After that load it compares the whole bank against the image.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
  typedef enum logic [1:0] {
    LD_IDLE  = 2'd0,
    LD_WAIT  = 2'd1,
    LD_RUN   = 2'd2,
    LD_FLUSH = 2'd3
  } ld_state_e;

  // Cycles that the busy flag of one complete load stays high.
  function automatic int unsigned load_span(int unsigned dly, int unsigned nreg,
                                            int unsigned tdiv);
    return dly + nreg * tdiv + 1;
  endfunction

  // Nonvolatile address holding the image byte of register index idx.
  function automatic int unsigned image_addr(int unsigned base, int unsigned idx);
    return base + idx;
  endfunction
endpackage

// File: rtl/cbl_timebase.sv
module cbl_timebase #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [TW-1:0] div_cnt;

  assign tick = run && (div_cnt == TW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             div_cnt <= '0;
    else if (!run || tick)  div_cnt <= '0;
    else                    div_cnt <= div_cnt + 1'b1;
  end
endmodule

// File: rtl/cbl_load_seq.sv
module cbl_load_seq import cbl_pkg::*; #(
  parameter int NREG      = 70,
  parameter int AW        = 7,
  parameter int DELAY_CYC = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          power_ok,
  input  logic          start,
  input  logic          tick,
  output logic          run,
  output logic          busy,
  output logic          rd_stb,
  output logic [AW-1:0] rd_idx,
  output logic          wr_stb,
  output logic [AW-1:0] wr_idx
);
  localparam int DLW = $clog2(DELAY_CYC + 1);

  ld_state_e     state;
  logic [DLW-1:0] dly_cnt;
  logic [AW-1:0] idx;
  logic          pend;
  logic [AW-1:0] pend_idx;

  assign run    = (state == LD_RUN);
  assign busy   = (state != LD_IDLE);
  assign rd_stb = run && tick;
  assign rd_idx = idx;
  assign wr_stb = pend;
  assign wr_idx = pend_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= LD_IDLE;
      dly_cnt  <= '0;
      idx      <= '0;
      pend     <= 1'b0;
      pend_idx <= '0;
    end else if (!power_ok) begin
      state <= LD_IDLE;
      pend  <= 1'b0;
    end else begin
      pend     <= rd_stb;
      pend_idx <= idx;
      unique case (state)
        LD_IDLE: if (start) begin
          state   <= LD_WAIT;
          dly_cnt <= '0;
          idx     <= '0;
        end
        LD_WAIT: begin
          if (dly_cnt == DLW'(DELAY_CYC - 1)) state <= LD_RUN;
          else                                dly_cnt <= dly_cnt + 1'b1;
        end
        LD_RUN: if (tick) begin
          idx <= idx + 1'b1;
          if (idx == AW'(NREG - 1)) state <= LD_FLUSH;
        end
        LD_FLUSH: state <= LD_IDLE;
        default:  state <= LD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cbl_prog_timer.sv
module cbl_prog_timer #(
  parameter int PROG_CYC = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic power_ok,
  input  logic start,
  output logic busy
);
  localparam int PW = $clog2(PROG_CYC + 1);

  logic [PW-1:0] remain;

  assign busy = (remain != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        remain <= '0;
    else if (!power_ok) remain <= '0;
    else if (start)    remain <= PW'(PROG_CYC);
    else if (busy)     remain <= remain - 1'b1;
  end
endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader import cbl_pkg::*; #(
  parameter int          NREG           = 70,
  parameter int          AW             = 7,
  parameter int          DW             = 8,
  parameter int          NV_AW          = 16,
  parameter int unsigned NV_BASE        = 32'h8000,
  parameter int          DELAY_CYC      = 20,
  parameter int          TICK_DIV       = 4,
  parameter int          PROG_CYC       = 300,
  parameter int          LOAD_LIMIT_CYC = 350
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uvlo_ok,
  input  logic             reboot_req,
  input  logic             host_req,
  input  logic             host_nv,
  input  logic [AW-1:0]    host_addr,
  input  logic [DW-1:0]    host_wdata,
  output logic             host_ack,
  output logic             host_nack,
  output logic [NV_AW-1:0] nv_addr,
  output logic             nv_rd,
  input  logic [DW-1:0]    nv_rdata,
  output logic             nv_wr,
  output logic [DW-1:0]    nv_wdata,
  output logic             reg_we,
  output logic [AW-1:0]    reg_waddr,
  output logic [DW-1:0]    reg_wdata,
  output logic             load_busy,
  output logic             prog_busy
);
  localparam logic [AW:0] NREG_W = (AW+1)'(NREG);

  // Named internal events, also observed by the bound checker.
  logic          uvlo_q;
  logic          power_rise;
  logic          reboot_take;
  logic          load_start;
  logic          ld_run;
  logic          ld_tick;
  logic          ld_rd;
  logic [AW-1:0] ld_rd_idx;
  logic          ld_wr;
  logic [AW-1:0] ld_wr_idx;
  logic          host_legal;
  logic          host_open;
  logic          host_accept;
  logic          prog_start;
  logic          reg_direct;
  logic [AW-1:0] pg_idx;

  assign power_rise  = uvlo_ok && !uvlo_q;
  assign reboot_take = reboot_req && uvlo_ok && !load_busy && !prog_busy;
  assign load_start  = power_rise || reboot_take;

  assign host_legal  = ({1'b0, host_addr} < NREG_W);
  assign host_open   = uvlo_ok && !load_busy && !prog_busy && !load_start;
  assign host_accept = host_req && host_open && host_legal;
  assign prog_start  = host_accept && host_nv;
  assign reg_direct  = host_accept && !host_nv;

  cbl_timebase #(.TICK_DIV(TICK_DIV)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(ld_run), .tick(ld_tick)
  );

  cbl_load_seq #(.NREG(NREG), .AW(AW), .DELAY_CYC(DELAY_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .power_ok(uvlo_ok), .start(load_start),
    .tick(ld_tick), .run(ld_run), .busy(load_busy), .rd_stb(ld_rd),
    .rd_idx(ld_rd_idx), .wr_stb(ld_wr), .wr_idx(ld_wr_idx)
  );

  cbl_prog_timer #(.PROG_CYC(PROG_CYC)) u_pgm (
    .clk(clk), .rst_n(rst_n), .power_ok(uvlo_ok), .start(prog_start),
    .busy(prog_busy)
  );

  assign nv_rd   = ld_rd;
  assign nv_addr = NV_AW'(image_addr(NV_BASE, nv_wr ? 32'(pg_idx) : 32'(ld_rd_idx)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uvlo_q    <= 1'b0;
      host_ack  <= 1'b0;
      host_nack <= 1'b0;
      reg_we    <= 1'b0;
      reg_waddr <= '0;
      reg_wdata <= '0;
      nv_wr     <= 1'b0;
      nv_wdata  <= '0;
      pg_idx    <= '0;
    end else begin
      uvlo_q    <= uvlo_ok;
      host_ack  <= host_accept;
      host_nack <= host_req && !host_accept;
      reg_we    <= ld_wr || reg_direct;
      if (ld_wr) begin
        reg_waddr <= ld_wr_idx;
        reg_wdata <= nv_rdata;
      end else if (reg_direct) begin
        reg_waddr <= host_addr;
        reg_wdata <= host_wdata;
      end
      nv_wr <= prog_start;
      if (prog_start) begin
        pg_idx   <= host_addr;
        nv_wdata <= host_wdata;
      end
    end
  end
endmodule

// File: rtl/cbl_checker.sv
module cbl_checker #(
  parameter int          NREG           = 70,
  parameter int          AW             = 7,
  parameter int          NV_AW          = 16,
  parameter int unsigned NV_BASE        = 32'h8000,
  parameter int          LOAD_LIMIT_CYC = 350
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_req,
  input logic             host_ack,
  input logic             host_nack,
  input logic             load_busy,
  input logic             prog_busy,
  input logic             load_start,
  input logic             nv_rd,
  input logic             nv_wr,
  input logic [NV_AW-1:0] nv_addr,
  input logic             reg_we,
  input logic [AW-1:0]    reg_waddr
);
  int unsigned load_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         load_len <= 0;
    else if (load_busy) load_len <= load_len + 1;
    else                load_len <= 0;
  end

  AST_ACK_NACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(host_ack && host_nack)); // R9
  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n) host_req |=> (host_ack || host_nack)); // R9
  AST_NO_ACCEPT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) host_ack |-> $past(!load_busy && !prog_busy)); // R3
  AST_LOAD_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) load_start |=> load_busy); // R1
  AST_LOAD_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) load_len <= LOAD_LIMIT_CYC); // R4
  AST_IMAGE_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n) nv_rd |-> (32'(nv_addr) >= NV_BASE && 32'(nv_addr) < NV_BASE + NREG)); // R5
  AST_REG_INDEX_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) reg_we |-> (32'(reg_waddr) < NREG)); // R6
  AST_NO_READ_WHILE_PROG: assert property (@(posedge clk) disable iff (!rst_n) prog_busy |-> !nv_rd); // R7
  AST_PROG_FLAG_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n) nv_wr |-> prog_busy); // R7
endmodule

bind cfg_boot_loader cbl_checker #(
  .NREG(NREG), .AW(AW), .NV_AW(NV_AW), .NV_BASE(NV_BASE), .LOAD_LIMIT_CYC(LOAD_LIMIT_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_ack(host_ack),
  .host_nack(host_nack), .load_busy(load_busy), .prog_busy(prog_busy),
  .load_start(load_start), .nv_rd(nv_rd), .nv_wr(nv_wr), .nv_addr(nv_addr),
  .reg_we(reg_we), .reg_waddr(reg_waddr)
);

// File: tb/tb_cfg_boot_loader.sv
module tb_cfg_boot_loader;
  localparam int NREG = 70, AW = 7, DW = 8, NV_AW = 16;
  localparam int unsigned BASE = 32'h8000;
  localparam int DLY = 20, TICK = 4, PROG = 300, LIMIT = 350;
  localparam int EXP_SPAN = DLY + NREG * TICK + 1;
  localparam int NTBL = 8;
  // {nv, index[6:0], data[7:0], expect_ack}
  localparam logic [16:0] TBL [NTBL] = '{
    {1'b0, 7'h05, 8'hA5, 1'b1},
    {1'b0, 7'h45, 8'h3C, 1'b1},
    {1'b0, 7'h46, 8'hFF, 1'b0},
    {1'b0, 7'h7F, 8'hFF, 1'b0},
    {1'b0, 7'h00, 8'h11, 1'b1},
    {1'b1, 7'h10, 8'h77, 1'b1},
    {1'b0, 7'h01, 8'h22, 1'b0},
    {1'b1, 7'h11, 8'h66, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, uvlo_ok = 1'b0, reboot_req = 1'b0;
  logic host_req = 1'b0, host_nv = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0, nv_rdata = '0;
  logic host_ack, host_nack, nv_rd, nv_wr, reg_we, load_busy, prog_busy;
  logic [NV_AW-1:0] nv_addr;
  logic [DW-1:0] nv_wdata, reg_wdata;
  logic [AW-1:0] reg_waddr;

  always #2 clk = ~clk;

  cfg_boot_loader #(.NREG(NREG), .AW(AW), .DW(DW), .NV_AW(NV_AW), .NV_BASE(BASE),
    .DELAY_CYC(DLY), .TICK_DIV(TICK), .PROG_CYC(PROG), .LOAD_LIMIT_CYC(LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .uvlo_ok(uvlo_ok), .reboot_req(reboot_req),
    .host_req(host_req), .host_nv(host_nv), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_ack(host_ack), .host_nack(host_nack),
    .nv_addr(nv_addr), .nv_rd(nv_rd), .nv_rdata(nv_rdata), .nv_wr(nv_wr),
    .nv_wdata(nv_wdata), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .load_busy(load_busy), .prog_busy(prog_busy));

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] mem [NREG];
  logic [DW-1:0] regm [128];
  bit   reserved_hit = 0;
  int   busy_len, rd_cnt, first_rd, last_rd, ord_err, gap_err, reg_writes, nvw_cnt;
  bit   busy_prev = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Memory model and observation of every write the block makes.
  always @(negedge clk) begin
    if (load_busy) begin
      if (!busy_prev) begin
        busy_len = 0; rd_cnt = 0; first_rd = 0; last_rd = 0;
        ord_err = 0; gap_err = 0; reg_writes = 0;
      end
      busy_len++;
    end
    busy_prev = load_busy;
    if (nv_rd) begin
      if (32'(nv_addr) != BASE + rd_cnt) ord_err++;
      if (rd_cnt == 0) first_rd = busy_len;
      else if (busy_len - last_rd != TICK) gap_err++;
      last_rd = busy_len;
      rd_cnt++;
      nv_rdata = (32'(nv_addr) - BASE < NREG) ? mem[32'(nv_addr) - BASE] : '0;
    end
    if (nv_wr) begin
      nvw_cnt++;
      if (32'(nv_addr) - BASE < NREG) mem[32'(nv_addr) - BASE] = nv_wdata;
    end
    if (reg_we) begin
      reg_writes++;
      regm[reg_waddr] = reg_wdata;
      if (32'(reg_waddr) >= NREG) reserved_hit = 1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", "run timed out", 0, 1);
    finish_run();
  end

  task automatic host_op(input bit nv, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output bit ack, output bit nack, output bit we,
                         output logic [AW-1:0] wa, output logic [DW-1:0] wd,
                         output bit nw, output logic [NV_AW-1:0] na,
                         output logic [DW-1:0] nd, output bit pb);
    @(negedge clk);
    host_req = 1; host_nv = nv; host_addr = a; host_wdata = d;
    @(negedge clk);
    ack = host_ack; nack = host_nack; we = reg_we; wa = reg_waddr; wd = reg_wdata;
    nw = nv_wr; na = nv_addr; nd = nv_wdata; pb = prog_busy;
    host_req = 0;
  endtask

  task automatic pulse_reboot();
    @(negedge clk); reboot_req = 1;
    @(negedge clk); reboot_req = 0;
  endtask

  task automatic wait_load_end();
    @(negedge clk);
    while (load_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_full_load(input string req);
    int bad = 0;
    check(busy_len == EXP_SPAN, "R4", {req, " load span"}, busy_len, EXP_SPAN);
    check(busy_len <= LIMIT, "R4", {req, " load limit"}, busy_len, LIMIT);
    check(first_rd == DLY + TICK, "R2", {req, " first read cycle"}, first_rd, DLY + TICK);
    check(gap_err == 0, "R2", {req, " read spacing"}, gap_err, 0);
    check(ord_err == 0 && rd_cnt == NREG, "R5", {req, " read order/count"}, rd_cnt, NREG);
    for (int i = 0; i < NREG; i++) if (regm[i] !== mem[i]) bad++;
    check(bad == 0, "R5", {req, " register image mismatches"}, bad, 0);
    check(!reserved_hit, "R6", {req, " reserved index written"}, reserved_hit, 0);
  endtask

  initial begin
    bit ack, nack, we, nw, pb, saw_load;
    logic [AW-1:0] wa;
    logic [DW-1:0] wd, nd, keep;
    logic [NV_AW-1:0] na;
    int plen, writes_before;

    for (int i = 0; i < NREG; i++) mem[i] = 8'(i * 37 + 5);
    for (int i = 0; i < 128; i++) regm[i] = 8'hEE;

    repeat (3) @(negedge clk);
    check(!load_busy && !prog_busy && !reg_we && !nv_rd && !nv_wr && !host_ack && !host_nack,
          "reset", "outputs idle in reset", 0, 0);
    rst_n = 1;
    repeat (10) @(negedge clk);
    check(!load_busy && reg_writes == 0, "R11", "no load while uvlo low", load_busy, 0);
    host_op(0, 7'h02, 8'h33, ack, nack, we, wa, wd, nw, na, nd, pb);
    check(nack && !ack && !we, "R11", "request while uvlo low", ack, 0);

    // Power-up load (R1).
    @(negedge clk); uvlo_ok = 1;
    @(negedge clk);
    check(load_busy, "R1", "load starts on uvlo release", load_busy, 1);
    wait_load_end();
    check_full_load("R1 power-up");

    // Reboot load with a host request and a second reboot inside it (R3, R1).
    pulse_reboot();
    check(load_busy, "R1", "reboot starts load", load_busy, 1);
    repeat (30) @(negedge clk);
    host_op(0, 7'h03, 8'h5A, ack, nack, we, wa, wd, nw, na, nd, pb);
    check(nack && !ack, "R3", "request during load nacked", ack, 0);
    pulse_reboot();
    wait_load_end();
    check_full_load("R3 reboot");
    check(reg_writes == NREG, "R3", "no queued register write", reg_writes, NREG);
    check(regm[3] == mem[3], "R3", "refused data not applied", regm[3], mem[3]);

    // Table of host operations after the load.
    for (int k = 0; k < NTBL; k++) begin
      logic [16:0] e;
      e = TBL[k];
      keep = regm[e[15:9]];
      writes_before = nvw_cnt;
      host_op(e[16], e[15:9], e[8:1], ack, nack, we, wa, wd, nw, na, nd, pb);
      check(ack == e[0] && nack == !e[0], "R9", $sformatf("vector %0d ack", k), ack, e[0]);
      if (e[0] && !e[16]) begin
        check(we && wa == e[15:9] && wd == e[8:1] && !nw, "R8",
              $sformatf("vector %0d direct write", k), {wa, wd}, {e[15:9], e[8:1]});
      end else if (e[0] && e[16]) begin
        check(nw && 32'(na) == BASE + e[15:9] && nd == e[8:1] && pb, "R7",
              $sformatf("vector %0d program start", k), 32'(na), BASE + e[15:9]);
        check(!we, "R10", $sformatf("vector %0d register untouched", k), we, 0);
      end else begin
        check(!we && !nw, e[15:9] >= NREG ? "R6" : "R7",
              $sformatf("vector %0d refused, no write", k), {we, nw}, 0);
      end
      @(negedge clk);
      if (!(e[0] && !e[16]))
        check(regm[e[15:9]] == keep && (nvw_cnt == writes_before + (e[0] ? 1 : 0)),
              "R10", $sformatf("vector %0d register kept", k), regm[e[15:9]], keep);
    end
    while (prog_busy) @(negedge clk);

    // Programming cycle length, with a reboot attempt inside it.
    keep = regm[7'h20];
    host_op(1, 7'h20, 8'h99, ack, nack, we, wa, wd, nw, na, nd, pb);
    check(ack && nw, "R7", "program accepted", ack, 1);
    plen = 0; saw_load = 0;
    while (prog_busy) begin
      plen++;
      reboot_req = (plen == 10);
      if (load_busy || nv_rd) saw_load = 1;
      @(negedge clk);
    end
    reboot_req = 0;
    check(plen == PROG, "R7", "prog_busy length", plen, PROG);
    check(!saw_load, "R1", "reboot ignored while programming", saw_load, 0);
    check(regm[7'h20] == keep, "R10", "register unchanged by program", regm[7'h20], keep);

    // Next load brings programmed bytes in and replaces direct writes.
    pulse_reboot();
    wait_load_end();
    check_full_load("R10 reload");
    check(regm[7'h20] == 8'h99 && regm[7'h10] == 8'h77, "R10", "programmed bytes loaded",
          regm[7'h20], 8'h99);
    check(regm[5] == mem[5], "R11", "direct write replaced by load", regm[5], mem[5]);

    // Supply drop in the middle of a load.
    pulse_reboot();
    repeat (50) @(negedge clk);
    uvlo_ok = 0;
    @(negedge clk);
    check(!load_busy, "R11", "load aborted on supply drop", load_busy, 0);
    host_op(1, 7'h04, 8'h44, ack, nack, we, wa, wd, nw, na, nd, pb);
    check(nack && !nw, "R11", "request nacked while supply low", nack, 1);
    repeat (5) @(negedge clk);
    uvlo_ok = 1;
    wait_load_end();
    check_full_load("R11 power return");

    finish_run();
  end
endmodule